// File: doc/BRIEF.md
# Serial ADC readout controller

This block is the serial clock master for a 14-bit successive-approximation converter that has a single data output. A one-cycle `start` request, accepted only while the block is idle, pulls the converter's chip select low. The block then issues exactly 24 serial clock pulses, sampling the data line on every rising edge, and releases chip select after the last falling edge. The incoming stream opens with eight zero bits. The 14 result bits follow, most significant first. The block keeps those 14 bits and drops whatever arrives after them.

Two address lines drive an external 4-to-1 analog multiplexer. Each frame reports the channel whose sample the frame converts, which is the address presented when chip select fell. At the first rising serial clock edge of the frame, the block advances the address round-robin. The next input then has the rest of the conversion to slew and settle before its own acquisition. The serial clock rate is set by a half-period divider parameter. With a 100 MHz system clock, the default of 11 gives about 4.55 MHz. Any value from 11 to 500 keeps the clock within the converter's 100 kHz to 4.8 MHz window.

Top module: `adc_readout_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `adc_cs_n` is 1, `adc_sclk` is 0, `busy` and `result_valid` are 0, and `mux_addr` is 0.
- R2: A `start` sampled high while idle drives `adc_cs_n` low and `busy` high in the next cycle. `busy` stays high for the whole frame, including the chip-select-high gap after it.
- R3: Each frame has exactly 24 rising edges of `adc_sclk`, spaced 2*HALF_DIV system clocks apart. `adc_sclk` idles low and is low whenever `adc_cs_n` is high.
- R4: The data line is sampled at each rising `adc_sclk` edge. Sampled bits 9 through 22, counted from 1, form `result`, with bit 9 as the MSB. Bits 23 and 24 do not affect `result`.
- R5: `result_valid` is a single-cycle pulse. It rises 48*HALF_DIV cycles after the edge that accepted `start`, in the first cycle in which `adc_cs_n` is high again. `adc_cs_n` stays low from acceptance until that cycle.
- R6: `result_ch` equals the value `mux_addr` had when the frame started. `mux_addr` advances by one (NUM_CH-1 wraps to 0) at the first rising `adc_sclk` edge of each frame and holds its value at all other times.
- R7: `lead_err` is valid with `result_valid`. It is 1 when any of sampled bits 1 to 8 was 1, and 0 otherwise.
- R8: A `start` that arrives while `busy` is high is ignored. It neither restarts the frame, nor shifts the `result_valid` timing, nor queues another frame.
- R9: With `start` held high, `adc_cs_n` stays high for 2*HALF_DIV+1 cycles between frames, which is at least one serial clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, taken only while idle |
| adc_sdata | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter, idles low |
| mux_addr | output | 2 | Analog multiplexer address |
| busy | output | 1 | Frame or inter-frame gap in progress |
| result_valid | output | 1 | One-cycle strobe for a new result |
| result | output | RES_W | Captured conversion result |
| result_ch | output | 2 | Channel the result was sampled from |
| lead_err | output | 1 | A leading bit was nonzero |

## Verification
Every timed result is measured in system clock edges counted from the edge that accepted `start`. The n-th serial clock rise falls on edge (2n-1)*HALF_DIV, and the multiplexer step falls on edge HALF_DIV together with the first rise. `result_valid`, `result`, `result_ch` and `lead_err` are due on edge 48*HALF_DIV, and with `start` held, chip select stays high for 2*HALF_DIV+1 edges before the next frame. The bench drives inputs and samples outputs on the falling system clock edge. It counts rising edges one at a time and compares each observation against these edge numbers, so every check lands in the exact cycle the design is due to change.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  localparam int MUX_ADDR_W = 2;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_SHIFT = 2'd1,
    FS_GAP   = 2'd2
  } fsm_state_t;

  // Round-robin successor of a channel index.
  function automatic logic [MUX_ADDR_W-1:0] next_chan(
    input logic [MUX_ADDR_W-1:0] cur,
    input int                    num_ch
  );
    if (int'(cur) >= num_ch - 1) return '0;
    return cur + 1'b1;
  endfunction

  // True when a zero-based sample index falls in [lo, lo+width).
  function automatic logic in_window(input int idx, input int lo, input int width);
    return (idx >= lo) && (idx < lo + width);
  endfunction

  // System clocks from accepted start to the last falling serial edge.
  function automatic int frame_len_cycles(input int half_div, input int clks);
    return 2 * half_div * clks;
  endfunction

endpackage

// File: rtl/adc_sclk_divider.sv
module adc_sclk_divider #(
  parameter int HALF_DIV = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_frame_fsm.sv
module adc_frame_fsm
  import adc_rd_pkg::*;
#(
  parameter int FRAME_CLKS = 24,
  parameter int GAP_TICKS  = 2,
  parameter int IDX_W      = $clog2(FRAME_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  output logic             cs_n,
  output logic             sclk,
  output logic             busy,
  output logic             run,
  output logic             start_ok,
  output logic             rise_evt,
  output logic             frame_end,
  output logic [IDX_W-1:0] bit_idx
);
  localparam int GW = $clog2(GAP_TICKS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_CLKS);
  localparam logic [GW-1:0]    GAP_TOP  = GW'(GAP_TICKS - 1);

  fsm_state_t    state;
  logic [GW-1:0] gap_cnt;
  logic          fall_evt;

  assign run       = (state != FS_IDLE);
  assign busy      = run;
  assign start_ok  = (state == FS_IDLE) && start;
  assign rise_evt  = (state == FS_SHIFT) && tick && !sclk;
  assign fall_evt  = (state == FS_SHIFT) && tick && sclk;
  assign frame_end = fall_evt && (bit_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= FS_IDLE;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      bit_idx <= '0;
      gap_cnt <= '0;
    end else begin
      case (state)
        FS_IDLE: begin
          if (start) begin
            state   <= FS_SHIFT;
            cs_n    <= 1'b0;
            sclk    <= 1'b0;
            bit_idx <= '0;
          end
        end
        FS_SHIFT: begin
          if (rise_evt) begin
            sclk    <= 1'b1;
            bit_idx <= bit_idx + 1'b1;
          end
          if (fall_evt) begin
            sclk <= 1'b0;
            if (frame_end) begin
              state   <= FS_GAP;
              cs_n    <= 1'b1;
              gap_cnt <= '0;
            end
          end
        end
        FS_GAP: begin
          if (tick) begin
            if (gap_cnt == GAP_TOP) state <= FS_IDLE;
            else                    gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: state <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_rx_shifter.sv
module adc_rx_shifter
  import adc_rd_pkg::*;
#(
  parameter int RES_W      = 14,
  parameter int LEAD_W     = 8,
  parameter bit CHECK_LEAD = 1'b1,
  parameter int IDX_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             rise_evt,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             sdata,
  input  logic             frame_end,
  output logic [RES_W-1:0] result,
  output logic             lead_err
);
  logic [RES_W-1:0] sh;
  logic             in_res;
  logic             in_lead;

  assign in_res  = in_window(int'(bit_idx), LEAD_W, RES_W);
  assign in_lead = in_window(int'(bit_idx), 0, LEAD_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      result <= '0;
    end else begin
      if (clear)                  sh <= '0;
      else if (rise_evt && in_res) sh <= {sh[RES_W-2:0], sdata};
      if (frame_end)              result <= sh;
    end
  end

  generate
    if (CHECK_LEAD) begin : g_lead_chk
      logic lead_acc;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          lead_acc <= 1'b0;
          lead_err <= 1'b0;
        end else begin
          if (clear)                    lead_acc <= 1'b0;
          else if (rise_evt && in_lead) lead_acc <= lead_acc | sdata;
          if (frame_end)                lead_err <= lead_acc;
        end
      end
    end else begin : g_no_lead_chk
      assign lead_err = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/adc_chan_stepper.sv
module adc_chan_stepper
  import adc_rd_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int STEP_RISE = 1,
  parameter int IDX_W     = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_ok,
  input  logic                  rise_evt,
  input  logic [IDX_W-1:0]      bit_idx,
  output logic [MUX_ADDR_W-1:0] mux_addr,
  output logic [MUX_ADDR_W-1:0] tag
);
  logic step;

  assign step = rise_evt && (int'(bit_idx) == STEP_RISE - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mux_addr <= '0;
      tag      <= '0;
    end else begin
      if (start_ok) tag      <= mux_addr;
      if (step)     mux_addr <= next_chan(mux_addr, NUM_CH);
    end
  end
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_rd_pkg::*;
#(
  parameter int HALF_DIV   = 11,
  parameter int RES_W      = 14,
  parameter int LEAD_W     = 8,
  parameter int FRAME_CLKS = 24,
  parameter int NUM_CH     = 4,
  parameter int STEP_RISE  = 1,
  parameter bit CHECK_LEAD = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  adc_sdata,
  output logic                  adc_cs_n,
  output logic                  adc_sclk,
  output logic [MUX_ADDR_W-1:0] mux_addr,
  output logic                  busy,
  output logic                  result_valid,
  output logic [RES_W-1:0]      result,
  output logic [MUX_ADDR_W-1:0] result_ch,
  output logic                  lead_err
);
  localparam int IDX_W     = $clog2(FRAME_CLKS + 1);
  localparam int GAP_TICKS = 2;

  logic             div_tick;
  logic             run;
  logic             start_ok;
  logic             rise_evt;
  logic             frame_end;
  logic [IDX_W-1:0] bit_idx;

  adc_sclk_divider #(.HALF_DIV(HALF_DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (div_tick)
  );

  adc_frame_fsm #(
    .FRAME_CLKS(FRAME_CLKS),
    .GAP_TICKS (GAP_TICKS),
    .IDX_W     (IDX_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tick     (div_tick),
    .cs_n     (adc_cs_n),
    .sclk     (adc_sclk),
    .busy     (busy),
    .run      (run),
    .start_ok (start_ok),
    .rise_evt (rise_evt),
    .frame_end(frame_end),
    .bit_idx  (bit_idx)
  );

  adc_rx_shifter #(
    .RES_W     (RES_W),
    .LEAD_W    (LEAD_W),
    .CHECK_LEAD(CHECK_LEAD),
    .IDX_W     (IDX_W)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_ok),
    .rise_evt (rise_evt),
    .bit_idx  (bit_idx),
    .sdata    (adc_sdata),
    .frame_end(frame_end),
    .result   (result),
    .lead_err (lead_err)
  );

  adc_chan_stepper #(
    .NUM_CH   (NUM_CH),
    .STEP_RISE(STEP_RISE),
    .IDX_W    (IDX_W)
  ) u_chan (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_ok(start_ok),
    .rise_evt(rise_evt),
    .bit_idx (bit_idx),
    .mux_addr(mux_addr),
    .tag     (result_ch)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) result_valid <= 1'b0;
    else        result_valid <= frame_end;
  end
endmodule

// File: rtl/adc_readout_sva.sv
module adc_readout_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       cs_n,
  input logic       sclk,
  input logic       busy,
  input logic       result_valid,
  input logic [1:0] mux_addr,
  input logic       div_tick,
  input logic       frame_end
);
  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_sclk_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> $past(div_tick));

  assert_end_on_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (!cs_n && sclk));

  assert_busy_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  assert_start_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(!busy) && $past(start)));

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  assert_valid_after_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (cs_n && !$past(cs_n)));

  assert_mux_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> $stable(mux_addr));
endmodule

bind adc_readout_ctrl adc_readout_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .cs_n        (adc_cs_n),
  .sclk        (adc_sclk),
  .busy        (busy),
  .result_valid(result_valid),
  .mux_addr    (mux_addr),
  .div_tick    (div_tick),
  .frame_end   (frame_end)
);

// File: tb/adc_readout_ctrl_bench.sv
`timescale 1ns/1ps
module adc_readout_ctrl_bench;
  localparam int HD = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sdata = 1'b0;
  logic        cs_n;
  logic        sclk;
  logic [1:0]  mux;
  logic        busy;
  logic        valid;
  logic [13:0] result;
  logic [1:0]  res_ch;
  logic        lead_err;

  int total = 0;
  int bad = 0;
  int wd = 0;
  int exp_ch = 0;

  logic [23:0] adc_word = '0;
  int          adc_idx = 0;

  always #5 clk = ~clk;

  adc_readout_ctrl #(.HALF_DIV(HD)) u_adc_readout_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .adc_sdata   (sdata),
    .adc_cs_n    (cs_n),
    .adc_sclk    (sclk),
    .mux_addr    (mux),
    .busy        (busy),
    .result_valid(valid),
    .result      (result),
    .result_ch   (res_ch),
    .lead_err    (lead_err)
  );

  // Converter model: first bit at chip select fall, next bit on each falling sclk.
  always @(negedge cs_n) begin
    adc_idx = 0;
    sdata   = adc_word[23];
  end
  always @(negedge sclk) begin
    if (!cs_n && adc_idx < 23) begin
      adc_idx = adc_idx + 1;
      sdata   = adc_word[23 - adc_idx];
    end
  end

  always @(posedge clk) begin
    wd = wd + 1;
    if (wd == 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL R5 watchdog expired actual=%0d expected<%0d", wd, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int nxt(input int c);
    return (c == 3) ? 0 : c + 1;
  endfunction

  // Sets the converter word and raises start; returns at the negedge after the accepting edge.
  task automatic launch(input logic [7:0] lead, input logic [13:0] res,
                        input logic [1:0] tail, input bit hold);
    adc_word = {lead, res, tail};
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (!hold) start = 1'b0;
  endtask

  // Entered at the negedge after the accepting edge S.
  task automatic do_frame(input logic [13:0] exp_res, input bit exp_err,
                          input bit poke, input bit hold, input string name);
    int n = 0;
    int rises = 0;
    int last_rise = 0;
    int step_at = -1;
    int gap_bad = 0;
    int cs_bad = 0;
    int extra = 0;
    logic prev = 1'b0;
    logic [1:0] mux0 = mux;
    chk(busy === 1'b1 && cs_n === 1'b0, "R2", {name, " busy/cs after start"},
        int'({busy, cs_n}), 2);
    chk(int'(mux0) == exp_ch, "R6", {name, " mux at frame start"}, int'(mux0), exp_ch);
    while (valid !== 1'b1 && n < 48 * HD + 60) begin
      @(posedge clk); n = n + 1;
      @(negedge clk);
      if (poke && n == 200) start = 1'b1;
      if (poke && n == 201) start = 1'b0;
      if (sclk === 1'b1 && prev === 1'b0) begin
        rises = rises + 1;
        if (rises > 1 && n - last_rise != 2 * HD) gap_bad = gap_bad + 1;
        last_rise = n;
      end
      if (mux !== mux0 && step_at < 0) step_at = rises;
      if (valid !== 1'b1 && cs_n !== 1'b0) cs_bad = cs_bad + 1;
      prev = sclk;
    end
    chk(n == 48 * HD, "R5", {name, " valid latency"}, n, 48 * HD);
    chk(cs_n === 1'b1, "R5", {name, " cs high at valid"}, int'(cs_n), 1);
    chk(cs_bad == 0, "R5", {name, " cs low through frame"}, cs_bad, 0);
    chk(rises == 24, "R3", {name, " sclk rises"}, rises, 24);
    chk(gap_bad == 0, "R3", {name, " sclk spacing"}, gap_bad, 0);
    chk(result === exp_res, "R4", {name, " result"}, int'(result), int'(exp_res));
    chk(lead_err === exp_err, "R7", {name, " lead_err"}, int'(lead_err), int'(exp_err));
    chk(int'(res_ch) == exp_ch, "R6", {name, " result_ch"}, int'(res_ch), exp_ch);
    chk(step_at == 1, "R6", {name, " mux step rise"}, step_at, 1);
    chk(int'(mux) == nxt(exp_ch), "R6", {name, " mux after step"}, int'(mux), nxt(exp_ch));
    exp_ch = nxt(exp_ch);
    @(posedge clk); @(negedge clk);
    chk(valid === 1'b0, "R5", {name, " valid one cycle"}, int'(valid), 0);
    if (!hold) begin
      while (busy === 1'b1) begin
        @(posedge clk); @(negedge clk);
        if (valid === 1'b1) extra = extra + 1;
      end
      chk(extra == 0, "R8", {name, " no extra valid"}, extra, 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0, "R1", "cs/sclk in reset", int'({cs_n, sclk}), 2);
    chk(busy === 1'b0 && valid === 1'b0, "R1", "busy/valid in reset", int'({busy, valid}), 0);
    chk(mux === 2'd0, "R1", "mux in reset", int'(mux), 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(cs_n === 1'b1 && busy === 1'b0, "R1", "idle after reset", int'({cs_n, busy}), 2);
    exp_ch = 0;
  endtask

  task automatic t_round_robin();
    launch(8'h00, 14'h3FFF, 2'b00, 1'b0); do_frame(14'h3FFF, 1'b0, 1'b0, 1'b0, "rr0");
    launch(8'h00, 14'h0000, 2'b00, 1'b0); do_frame(14'h0000, 1'b0, 1'b0, 1'b0, "rr1");
    launch(8'h00, 14'h2AAA, 2'b00, 1'b0); do_frame(14'h2AAA, 1'b0, 1'b0, 1'b0, "rr2");
    launch(8'h00, 14'h1555, 2'b00, 1'b0); do_frame(14'h1555, 1'b0, 1'b0, 1'b0, "rr3");
    launch(8'h00, 14'h2001, 2'b00, 1'b0); do_frame(14'h2001, 1'b0, 1'b0, 1'b0, "rr4wrap");
  endtask

  task automatic t_trailing();
    launch(8'h00, 14'h0000, 2'b11, 1'b0); do_frame(14'h0000, 1'b0, 1'b0, 1'b0, "tail_R4");
    launch(8'h00, 14'h1234, 2'b10, 1'b0); do_frame(14'h1234, 1'b0, 1'b0, 1'b0, "tail2_R4");
  endtask

  task automatic t_lead_err();
    launch(8'h01, 14'h0F0F, 2'b00, 1'b0); do_frame(14'h0F0F, 1'b1, 1'b0, 1'b0, "lead_lsb_R7");
    launch(8'h80, 14'h0001, 2'b01, 1'b0); do_frame(14'h0001, 1'b1, 1'b0, 1'b0, "lead_msb_R7");
    launch(8'h00, 14'h3000, 2'b00, 1'b0); do_frame(14'h3000, 1'b0, 1'b0, 1'b0, "lead_clean_R7");
  endtask

  task automatic t_ignore_start();
    int cs_low = 0;
    launch(8'h00, 14'h0ABC, 2'b00, 1'b0); do_frame(14'h0ABC, 1'b0, 1'b1, 1'b0, "poke_R8");
    repeat (3 * HD) begin
      @(posedge clk); @(negedge clk);
      if (cs_n !== 1'b1) cs_low = cs_low + 1;
    end
    chk(cs_low == 0 && busy === 1'b0, "R8", "no queued frame", cs_low, 0);
  endtask

  task automatic t_back_to_back();
    int gap = 2;
    launch(8'h00, 14'h3333, 2'b00, 1'b1); do_frame(14'h3333, 1'b0, 1'b0, 1'b1, "b2b_a");
    while (cs_n === 1'b1 && gap < 10 * HD) begin
      @(posedge clk); @(negedge clk);
      if (cs_n === 1'b1) gap = gap + 1;
    end
    chk(gap == 2 * HD + 1, "R9", "cs high gap", gap, 2 * HD + 1);
    chk(gap >= 2 * HD, "R9", "gap at least one sclk period", gap, 2 * HD);
    adc_word = {8'h00, 14'h0C3C, 2'b00};
    start = 1'b0;
    do_frame(14'h0C3C, 1'b0, 1'b0, 1'b0, "b2b_b");
  endtask

  initial begin
    t_reset();
    t_round_robin();
    t_trailing();
    t_lead_err();
    t_ignore_start();
    t_back_to_back();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule